// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block puts one voice sample per frame onto a serial data pin. The converter side hands over each sample as a parallel word on a valid/ready stream. The word is either an 8-bit companded code or a 13-bit two's-complement linear value. A one-entry holding register keeps the accepted sample. On the next rising edge of the frame sync, that sample is copied into a shift register and sent most significant bit first. Samples are sent one frame after they are accepted.

Two timing modes are chosen by a strap input. In fixed-rate mode every master clock edge is a data clock edge. An active-low slot strobe, with its own enable so that it can behave as open drain, marks the slot. In variable-rate mode a separate transmit bit clock sets the pace; it is synchronous to the master clock. The word repeats for as long as the frame sync stays high, and the pin goes high-impedance when the frame sync drops. An active-low mute input replaces the sample with an all-zero code.

Back-pressure rules: `smp_ready` is high only while the holding register is empty. A word is taken on a clock edge where `smp_valid` and `smp_ready` are both high. After that, `smp_ready` stays low until a frame start consumes the held word. While `smp_ready` is low, `smp_data` and `smp_valid` are ignored. The producer may keep `smp_valid` high for as long as it likes.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset `dout_en` is 0, `strb_n` is 1, `strb_oe` is 0 and `smp_ready` is 1.
- R2: With `rate_fix` = 1, a frame start (`fsync` seen high at a clock edge after being seen low at the previous edge) drives bit 1 after that edge. Each later master clock edge moves the pin on by one bit.
- R3: Words leave MSB first. A companded word is the 8 bits `smp_data[7:0]`. A linear word is 16 bits: `smp_data[12:0]` followed by three 0 bits.
- R4: In fixed-rate mode the slot lasts exactly 8 (companded) or 16 (linear) clock periods. During those periods `dout_en` = 1, `strb_n` = 0 and `strb_oe` = 1, and all three are released at the edge after the last bit. The level of `fsync` after the frame start has no effect.
- R5: With `rate_fix` = 0, bit 1 is driven after the edge at which the frame start is seen. The pin then moves on by one bit only at a clock edge where `tx_bclk` is high and was low at the previous edge.
- R6: In variable-rate mode, while `fsync` stays high, a bit-clock rise after the last bit restarts the same word from bit 1.
- R7: In variable-rate mode `dout_en` is 0 from the edge after the one at which `fsync` is seen low, even in the middle of a word. In this mode `strb_oe` stays 0 and `strb_n` stays 1.
- R8: If `mute_n` is 0 at the frame start, the whole word is zeros. The held sample is still consumed.
- R9: An accepted sample stays in the holding register until the next frame start, and that frame sends it. While `smp_ready` is 0, new data offered has no effect.
- R10: If no sample is held at a frame start, that frame sends all zeros. A sample accepted at the same edge as a frame start is kept for the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_fix | input | 1 | Strap: 1 selects fixed-rate, 0 variable-rate timing |
| tx_bclk | input | 1 | Transmit bit clock for variable-rate mode, synchronous to `clk` |
| fsync | input | 1 | Transmit frame sync |
| lin_sel | input | 1 | 1 selects the 16-bit linear word, 0 the 8-bit companded word |
| mute_n | input | 1 | Active-low mute, sampled at frame start |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready (holding register empty) |
| smp_data | input | 13 | Sample; companded code in bits 7:0 |
| dout | output | 1 | Serial data |
| dout_en | output | 1 | Tri-state enable for `dout` |
| strb_n | output | 1 | Active-low slot strobe level |
| strb_oe | output | 1 | Slot strobe pull-down enable (open-drain emulation) |

## Verification
The hold register's stream acceptance and the frame-start load that empties it can land on the same master clock edge. The bench provokes this by raising `smp_valid` and `fsync` on the same half cycle while the register is empty. The frame that starts then must carry all zeros and `smp_ready` must drop. The word offered must come out whole in the next frame. A second collision is the variable-rate frame sync falling while a bit-clock rise is pending. That case is judged by the pin being released mid-word with no extra bit reaching the monitor.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic {
    RATE_VAR = 1'b0,
    RATE_FIX = 1'b1
  } rate_mode_e;

  // per-cycle events produced by the timebase
  typedef struct packed {
    logic load;    // frame start: fsync seen rising
    logic tick;    // active data clock edge
    logic fs_low;  // fsync currently low
  } pcm_ev_t;

endpackage

// File: rtl/pcm_tx_timebase.sv
module pcm_tx_timebase
  import pcm_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rate_fix,
  input  logic    fsync,
  input  logic    tx_bclk,
  output pcm_ev_t ev
);

  logic fs_q;
  logic bclk_q;
  rate_mode_e mode;

  assign mode = rate_fix ? RATE_FIX : RATE_VAR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      fs_q   <= fsync;
      bclk_q <= tx_bclk;
    end
  end

  always_comb begin
    ev.load   = fsync & ~fs_q;
    ev.fs_low = ~fsync;
    ev.tick   = (mode == RATE_FIX) ? 1'b1 : (tx_bclk & ~bclk_q);
  end

endmodule

// File: rtl/pcm_tx_hold.sv
module pcm_tx_hold #(
  parameter int LIN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LIN_W-1:0] in_data,
  input  logic             take,
  output logic             full,
  output logic [LIN_W-1:0] data
);

  logic accept;

  assign in_ready = ~full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R9
  accept_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(data));

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int LIN_W = 13,
  parameter int CMP_W = 8,
  parameter int PAD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pcm_ev_t          ev,
  input  logic             rate_fix,
  input  logic             lin_sel,
  input  logic             mute_n,
  input  logic             hold_full,
  input  logic [LIN_W-1:0] hold_data,
  output logic             dout,
  output logic             dout_en,
  output logic             strb_n,
  output logic             strb_oe
);

  localparam int WORD_W = LIN_W + PAD_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_LIN = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_CMP = CNT_W'(CMP_W - 1);

  logic [WORD_W-1:0] lin_word;
  logic [WORD_W-1:0] cmp_word;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic              lin_q;
  logic              active;
  rate_mode_e        mode;

  assign mode = rate_fix ? RATE_FIX : RATE_VAR;

  generate
    if (PAD_W > 0) begin : g_lin_pad
      assign lin_word = {hold_data, {PAD_W{1'b0}}};
    end else begin : g_lin_nopad
      assign lin_word = hold_data;
    end
    if (WORD_W > CMP_W) begin : g_cmp_pad
      assign cmp_word = {hold_data[CMP_W-1:0], {(WORD_W-CMP_W){1'b0}}};
    end else begin : g_cmp_nopad
      assign cmp_word = hold_data[CMP_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!mute_n || !hold_full) new_word = '0;
    else if (lin_sel)          new_word = lin_word;
    else                       new_word = cmp_word;
  end

  assign last_idx = lin_q ? LAST_LIN : LAST_CMP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      shreg  <= '0;
      cnt    <= '0;
      lin_q  <= 1'b0;
      active <= 1'b0;
    end else if (ev.load) begin
      word_q <= new_word;
      shreg  <= new_word;
      cnt    <= '0;
      lin_q  <= lin_sel;
      active <= 1'b1;
    end else if (active) begin
      if (mode == RATE_VAR && ev.fs_low) begin
        active <= 1'b0;
      end else if (ev.tick) begin
        if (cnt == last_idx) begin
          if (mode == RATE_FIX) begin
            active <= 1'b0;
          end else begin
            shreg <= word_q;
            cnt   <= '0;
          end
        end else begin
          shreg <= shreg << 1;
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assign dout    = active & shreg[WORD_W-1];
  assign dout_en = active;
  assign strb_oe = active & (mode == RATE_FIX);
  assign strb_n  = ~strb_oe;

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.load |=> (dout_en && cnt == '0));

  // R4
  fixed_slot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_fix && dout_en && !ev.load && cnt == last_idx) |=> !dout_en);

  // R6
  var_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_fix && dout_en && !ev.fs_low && !ev.load && ev.tick && cnt == last_idx)
      |=> (dout_en && cnt == '0));

  // R7
  var_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_fix && ev.fs_low) |=> !dout_en);

  // R8
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.load && !mute_n) |=> (shreg == '0));

  // R10
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.load && !hold_full) |=> (shreg == '0));

  // R3
  bit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (cnt <= last_idx));

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int LIN_W = 13,
  parameter int CMP_W = 8,
  parameter int PAD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_fix,
  input  logic             tx_bclk,
  input  logic             fsync,
  input  logic             lin_sel,
  input  logic             mute_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [LIN_W-1:0] smp_data,
  output logic             dout,
  output logic             dout_en,
  output logic             strb_n,
  output logic             strb_oe
);

  pcm_ev_t          ev;
  logic             hold_full;
  logic [LIN_W-1:0] hold_data;

  pcm_tx_timebase u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_fix (rate_fix),
    .fsync    (fsync),
    .tx_bclk  (tx_bclk),
    .ev       (ev)
  );

  pcm_tx_hold #(.LIN_W(LIN_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .in_ready (smp_ready),
    .in_data  (smp_data),
    .take     (ev.load),
    .full     (hold_full),
    .data     (hold_data)
  );

  pcm_tx_shifter #(.LIN_W(LIN_W), .CMP_W(CMP_W), .PAD_W(PAD_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .rate_fix  (rate_fix),
    .lin_sel   (lin_sel),
    .mute_n    (mute_n),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .dout      (dout),
    .dout_en   (dout_en),
    .strb_n    (strb_n),
    .strb_oe   (strb_oe)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dout_en && smp_ready));

endmodule

// File: tb/sim_pcm_tx_port.sv
module sim_pcm_tx_port;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_fix = 1'b1;
  logic tx_bclk = 1'b0;
  logic fsync = 1'b0;
  logic lin_sel = 1'b0;
  logic mute_n = 1'b1;
  logic smp_valid = 1'b0;
  logic [12:0] smp_data = '0;
  logic smp_ready, dout, dout_en, strb_n, strb_oe;

  int checks = 0;
  int fails = 0;
  bit exp_q[$];
  bit m_full = 1'b0;
  logic [12:0] m_data = '0;

  always #4 clk = ~clk;

  pcm_tx_port u0 (
    .clk(clk), .rst_n(rst_n), .rate_fix(rate_fix), .tx_bclk(tx_bclk),
    .fsync(fsync), .lin_sel(lin_sel), .mute_n(mute_n),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .dout(dout), .dout_en(dout_en), .strb_n(strb_n), .strb_oe(strb_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(input bit lin, input logic [12:0] d);
    return lin ? {d, 3'b000} : {d[7:0], 8'h00};
  endfunction

  // consume the model hold register at a frame start
  function automatic logic [15:0] frame_word(input bit lin, input bit mn);
    logic [15:0] w;
    w = (mn && m_full) ? mk_word(lin, m_data) : 16'h0000;
    m_full = 1'b0;
    return w;
  endfunction

  task automatic push_bits(input bit lin, input logic [15:0] w, input int count);
    for (int k = 0; k < count; k++) begin
      int n = lin ? 16 : 8;
      exp_q.push_back(w[15 - (k % n)]);
    end
  endtask

  task automatic send_sample(input logic [12:0] d);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    m_full = 1'b1;
    m_data = d;
  endtask

  task automatic fixed_frame(input bit lin, input bit mn, input string req);
    logic [15:0] w;
    int n = lin ? 16 : 8;
    @(negedge clk);
    lin_sel = lin;
    mute_n  = mn;
    fsync   = 1'b1;
    w = frame_word(lin, mn);
    push_bits(lin, w, n);
    repeat (3) @(negedge clk);
    fsync = 1'b0;
    repeat (n + 2) @(negedge clk);
    mute_n = 1'b1;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(strb_oe == 1'b0 && strb_n == 1'b1 && dout_en == 1'b0, "R4", strb_oe, 0);
  endtask

  task automatic var_frame(input bit lin, input bit mn, input int nclk, input string req);
    logic [15:0] w;
    @(negedge clk);
    lin_sel = lin;
    mute_n  = mn;
    fsync   = 1'b1;
    w = frame_word(lin, mn);
    push_bits(lin, w, nclk);
    repeat (2) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      tx_bclk = 1'b1;
      repeat (2) @(negedge clk);
      tx_bclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    fsync = 1'b0;
    @(negedge clk);
    chk(dout_en == 1'b0, "R7", dout_en, 0);
    chk(strb_oe == 1'b0 && strb_n == 1'b1, "R7", strb_oe, 0);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    mute_n = 1'b1;
  endtask

  // scoreboard monitor, fixed-rate: one bit per master clock
  always @(negedge clk) begin
    if (rst_n && rate_fix && dout_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", dout, -1);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(dout == e, "R2", dout, e);
      end
      chk(strb_n == 1'b0 && strb_oe == 1'b1, "R4", strb_n, 0);
    end
  end

  // scoreboard monitor, variable-rate: the bit shown before each bit-clock rise
  always @(posedge tx_bclk) begin
    #1;
    if (rst_n && !rate_fix && dout_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", dout, -1);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(dout == e, "R5", dout, e);
      end
      chk(strb_oe == 1'b0, "R7", strb_oe, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dout_en == 1'b0, "R1", dout_en, 0);
    chk(strb_n == 1'b1 && strb_oe == 1'b0, "R1", strb_oe, 0);
    chk(smp_ready == 1'b1, "R1", smp_ready, 1);

    // fixed-rate, companded then linear (R2, R3)
    send_sample(13'h0A5);
    fixed_frame(1'b0, 1'b1, "R3");
    send_sample(13'h1B3C);
    fixed_frame(1'b1, 1'b1, "R3");

    // mute (R8): sample consumed, zeros sent
    send_sample(13'h0FF);
    fixed_frame(1'b0, 1'b0, "R8");
    chk(smp_ready == 1'b1, "R8", smp_ready, 1);

    // back-pressure (R9): offered data ignored while full
    send_sample(13'h155);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 13'h0AA;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(smp_ready == 1'b0, "R9", smp_ready, 0);
    end
    smp_valid = 1'b0;
    fixed_frame(1'b0, 1'b1, "R9");
    chk(smp_ready == 1'b1, "R9", smp_ready, 1);

    // underrun (R10)
    fixed_frame(1'b1, 1'b1, "R10");

    // same-edge accept and frame start (R10)
    @(negedge clk);
    lin_sel   = 1'b0;
    fsync     = 1'b1;
    smp_valid = 1'b1;
    smp_data  = 13'h03C;
    push_bits(1'b0, 16'h0000, 8);
    @(negedge clk);
    smp_valid = 1'b0;
    m_full = 1'b1;
    m_data = 13'h03C;
    chk(smp_ready == 1'b0, "R10", smp_ready, 0);
    repeat (2) @(negedge clk);
    fsync = 1'b0;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    fixed_frame(1'b0, 1'b1, "R10");

    // variable-rate mode
    @(negedge clk);
    rate_fix = 1'b0;
    repeat (2) @(negedge clk);
    send_sample(13'h1234);
    var_frame(1'b1, 1'b1, 16, "R5");
    send_sample(13'h0C3);
    var_frame(1'b0, 1'b1, 19, "R6");
    send_sample(13'h0F0F);
    var_frame(1'b1, 1'b1, 5, "R7");
    send_sample(13'h1FFF);
    var_frame(1'b1, 1'b0, 16, "R8");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule